// File: doc/BRIEF.md
# Interrupt Source Aggregator with Set/Clear Enables

This block gathers a group of single-cycle interrupt source events into one interrupt line for a vectored interrupt controller. Each event is held in a pending register until software reads that register. The read returns the pending pattern and clears it in the same access. Software picks which sources may raise the combined line. It does this through two write-only registers: one turns sources on, the other turns them off. No read-modify-write of an enable word is ever needed.

The current enable state can be read back, inverted, as a mask word in which a 1 marks a disabled source. Pending bits record events whether or not the source is enabled. Only the combined output is gated. A source therefore shows up in the pending register even while it is disabled. The host uses a simple register bus with an address, write strobe, write data, read strobe and read data. Read data is registered and appears the cycle after the read strobe.

The register selector is decoded through an enumerated access kind with four named selections: PENDING (address 0), ON (address 1), OFF (address 2) and MASKVIEW (address 3). Every other address is unmapped.

Top module: `irq_aggregator`

## Requirements
- R1: A high `src_pulse[i]` sets pending bit i at the next clock edge, whether source i is enabled or not.
- R2: `irq_out` is high exactly when at least one source is both pending and enabled. With all sources disabled it stays low, even while bits are pending.
- R3: A read at address 0 returns the pending bits in `bus_rdata[NUM_SRC-1:0]` one cycle after the strobe, and clears every bit it returned.
- R4: A source event that arrives in the same cycle as a pending-register read is not lost. That bit is still pending after the read.
- R5: After reset no source is enabled, nothing is pending and `irq_out` is low.
- R6: Writing to address 1 enables every source whose `bus_wdata` bit is 1. Bits written as 0 leave the enable state unchanged.
- R7: Writing to address 2 disables every source whose `bus_wdata` bit is 1. Bits written as 0 leave the enable state unchanged.
- R8: A read at address 3 returns a 1 for each disabled source and a 0 for each enabled source, in bits `NUM_SRC-1:0`.
- R9: Reads of addresses 1 and 2, and of any unmapped address, return zero. Writes to addresses 0 and 3, and to unmapped addresses, change neither the pending nor the enable state.
- R10: Bits of `bus_rdata` above `NUM_SRC-1` always read as zero, and `bus_rdata` is zero in any cycle after which no read was strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | NUM_SRC | One bit per source; high for a cycle per event |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench walks every source through pending, read and clear with the source disabled. A design that gated the latch with the enable would read back zero there, and one that did not clear on read would return the bit twice. It sweeps enables up bit by bit and back down again, and checks the mask word and the combined line at each step. Writes of zero and writes to the read-only or unmapped slots must leave the state alone; a design that decoded a missing address bit would corrupt the enables. A source event placed in the same cycle as the pending read must survive it. A design that cleared after merging the events would drop that event silently.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register selection; the numeric values are the word addresses.
    typedef enum logic [1:0] {
        SEL_PENDING  = 2'd0,
        SEL_ON       = 2'd1,
        SEL_OFF      = 2'd2,
        SEL_MASKVIEW = 2'd3
    } reg_sel_e;

    localparam int SEL_BITS = 2;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_on,
    output logic              wr_off,
    output logic              rd_pending,
    output logic              rd_maskview
);

    localparam int HI_W = ADDR_W - SEL_BITS;

    reg_sel_e sel;
    logic     hit;

    assign sel = reg_sel_e'(addr[SEL_BITS-1:0]);
    assign hit = (addr[ADDR_W-1:SEL_BITS] == HI_W'(0));

    always_comb begin
        wr_on       = 1'b0;
        wr_off      = 1'b0;
        rd_pending  = 1'b0;
        rd_maskview = 1'b0;
        unique case (sel)
            SEL_PENDING:  rd_pending  = rd && hit;
            SEL_ON:       wr_on       = wr && hit;
            SEL_OFF:      wr_off      = wr && hit;
            SEL_MASKVIEW: rd_maskview = rd && hit;
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl #(
    parameter int NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] enable_q
);

    // Each bit is an independent set/clear flop; clear takes priority.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                enable_q[i] <= 1'b0;
            end else if (clr_vec[i]) begin
                enable_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                enable_q[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
    parameter int NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               rd_clear,
    output logic [NUM_SRC-1:0] status_q
);

    logic [NUM_SRC-1:0] kept;

    // Clear first, then merge new events, so a same-cycle event survives.
    assign kept = rd_clear ? '0 : status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= kept | src_pulse;
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 14,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    logic               wr_on;
    logic               wr_off;
    logic               rd_pending;
    logic               rd_maskview;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] rd_word;

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr        (bus_addr),
        .wr          (bus_wr),
        .rd          (bus_rd),
        .wr_on       (wr_on),
        .wr_off      (wr_off),
        .rd_pending  (rd_pending),
        .rd_maskview (rd_maskview)
    );

    assign set_vec = wr_on  ? bus_wdata[NUM_SRC-1:0] : '0;
    assign clr_vec = wr_off ? bus_wdata[NUM_SRC-1:0] : '0;

    irq_enable_ctrl #(.NUM_SRC(NUM_SRC)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .enable_q (enable_q)
    );

    irq_status_latch #(.NUM_SRC(NUM_SRC)) u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .rd_clear  (rd_pending),
        .status_q  (status_q)
    );

    always_comb begin
        rd_word = '0;
        if (rd_pending) begin
            rd_word = status_q;
        end else if (rd_maskview) begin
            rd_word = ~enable_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= {{PAD_W{1'b0}}, rd_word};
        end
    end

    assign irq_out = |(status_q & enable_q);

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int NUM_SRC = 14,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_pulse,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               bus_rd,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q
);

    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_ON   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_OFF  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(3);

    a_r1_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pulse != '0) |=> ((status_q & $past(src_pulse)) == $past(src_pulse)));

    a_r2_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !irq_out);

    a_r4_read_keeps_new_events: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_PEND) |=> (status_q == $past(src_pulse)));

    a_r3_read_returns_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_PEND) |=> (bus_rdata[NUM_SRC-1:0] == $past(status_q)));

    a_r5_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (enable_q == '0 && status_q == '0 && !irq_out));

    a_r6_on_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ON) |=>
        ((enable_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

    a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OFF) |=>
        ((enable_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

    a_r8_maskview_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_MASK) |=> (bus_rdata[NUM_SRC-1:0] == ~$past(enable_q)));

    a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .status_q  (status_q),
    .enable_q  (enable_q)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

    localparam int N  = 14;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam logic [N-1:0] ALL = {N{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_pulse = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] en_model = '0;
    logic [DW-1:0] rv;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_aggregator #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] v);
        @(negedge clk);
        src_pulse = v;
        @(negedge clk);
        src_pulse = '0;
    endtask

    function automatic logic [DW-1:0] ext(input logic [N-1:0] v);
        return {{(DW-N){1'b0}}, v};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: reset state
        check("R5 irq after reset", ext(irq_out), ext(1'b0));
        rd_reg(4'd3, rv); check("R5 all disabled (mask)", rv, ext(ALL));
        rd_reg(4'd0, rv); check("R5 nothing pending", rv, ext('0));
        // R10: idle read data is zero
        check("R10 idle rdata", bus_rdata, '0);

        // R1/R3/R2: each source pends while disabled, reads once, then clears
        for (int i = 0; i < N; i++) begin
            pulse(N'(1) << i);
            check("R2 disabled source no irq", ext(irq_out), ext(1'b0));
            rd_reg(4'd0, rv); check("R1 R3 pending bit", rv, ext(N'(1) << i));
            rd_reg(4'd0, rv); check("R3 cleared by read", rv, ext('0));
        end

        // R6: enable sweep, with zero writes in between
        for (int i = 0; i < N; i++) begin
            wr_reg(4'd1, ext(N'(1) << i));
            en_model = en_model | (N'(1) << i);
            wr_reg(4'd1, '0);
            rd_reg(4'd3, rv); check("R6 R8 mask after enable", rv, ext(~en_model));
        end

        // R9: read-only and unmapped slots
        rd_reg(4'd1, rv); check("R9 on-reg reads zero", rv, '0);
        rd_reg(4'd2, rv); check("R9 off-reg reads zero", rv, '0);
        for (int a = 4; a < 16; a++) begin
            rd_reg(AW'(a), rv); check("R9 unmapped reads zero", rv, '0);
            wr_reg(AW'(a), '1);
        end
        wr_reg(4'd3, '1);
        rd_reg(4'd3, rv); check("R9 writes to mask/unmapped ignored", rv, ext(~en_model));
        pulse(N'(5));
        wr_reg(4'd0, '1);
        rd_reg(4'd0, rv); check("R9 write to pending ignored", rv, ext(N'(5)));

        // R7/R2: disable sweep with a pending source per step
        for (int i = 0; i < N; i++) begin
            pulse(N'(1) << i);
            check("R2 enabled pending raises irq", ext(irq_out), ext(1'b1));
            wr_reg(4'd2, '0);
            check("R7 zero write keeps irq", ext(irq_out), ext(1'b1));
            wr_reg(4'd2, ext(N'(1) << i));
            en_model = en_model & ~(N'(1) << i);
            check("R7 R2 disabled drops irq", ext(irq_out), ext(1'b0));
            rd_reg(4'd3, rv); check("R7 R8 mask after disable", rv, ext(~en_model));
            rd_reg(4'd0, rv); check("R1 pending kept while disabled", rv, ext(N'(1) << i));
        end

        // R2: mixed patterns
        wr_reg(4'd1, ext(N'(14'h0A0C)));
        pulse(N'(14'h0101));
        check("R2 no overlap no irq", ext(irq_out), ext(1'b0));
        pulse(N'(14'h0008));
        check("R2 overlap raises irq", ext(irq_out), ext(1'b1));
        rd_reg(4'd0, rv); check("R3 mixed pending", rv, ext(N'(14'h0109)));
        check("R2 read clears irq", ext(irq_out), ext(1'b0));

        // R4: event in the same cycle as the pending read
        pulse(N'(14'h0004));
        @(negedge clk);
        bus_addr = 4'd0; bus_rd = 1'b1; src_pulse = N'(14'h2001);
        @(negedge clk);
        bus_rd = 1'b0; src_pulse = '0;
        check("R4 read returns old pending", bus_rdata, ext(N'(14'h0004)));
        rd_reg(4'd0, rv); check("R4 same-cycle event kept", rv, ext(N'(14'h2001)));

        // R10: upper bits zero on mask read
        wr_reg(4'd2, '1);
        rd_reg(4'd3, rv); check("R10 upper bits zero", rv, ext(ALL));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule